// File: doc/BRIEF.md
# Passive Two-Phase Peripheral Bus Transfer Monitor

This block sits beside a simple peripheral bus (APB-style, without wait states or slave error signalling) and only listens. Each clock it samples select, enable, direction, address, write data and read data. A legal transfer is a setup cycle (select high, enable low) followed directly by an access cycle (select and enable high). During that pair, address, direction and, for writes, write data must hold the same value. Every transfer that fits this pattern produces a one-cycle record on the outputs that gives direction, address and data.

Any cycle that does not fit a legal sequence counts as a protocol fault. The fault sets a sticky error flag and a two-bit code that names the kind of fault. The flag and the first code stay until reset. Recognition of later transfers goes on after a fault, so a user can keep logging traffic. The monitor drives nothing on the bus. A synchronous active-low reset sends it back to idle and clears the flag.

Top module: `apbXferMonitor`

## Requirements
- R1: While `rstN` is low at a clock edge, the monitor returns to idle. After that edge `recValid`, `errFlag` and `errCode` are all 0.
- R2: A setup cycle followed by an access cycle with `wrIn`=1, where address and write data do not change, makes `recValid` high in the cycle after the access edge. In that cycle `recWrite`=1, `recAddr` is the transfer address and `recData` is the write data.
- R3: A read transfer (`wrIn`=0 in both phases) gives a record with `recWrite`=0 and `recData` equal to `rdataIn` as sampled in the access cycle. Read data in the setup cycle has no effect.
- R4: `recValid` is high for exactly one clock per completed transfer.
- R5: Enable high in a cycle that is not the access cycle of a pending setup is fault code 1. This covers enable with select low, and enable without a setup cycle just before it.
- R6: A setup cycle that is not followed by an access cycle is fault code 2, and no record comes from it. If the following cycle is itself a setup cycle, it starts a new transfer.
- R7: If address, direction or (for writes) write data differ between setup and access, that is fault code 3, and no record is produced.
- R8: `errFlag` goes high in the cycle after the first fault. It then holds together with the code of that first fault until reset. Later faults do not change the code. Later legal transfers still produce records.
- R9: An access cycle followed at once by a new setup cycle is legal, so back-to-back transfers produce one record each and no fault.
- R10: Idle cycles (select and enable low) produce neither records nor faults, whatever the address and data lines carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| selIn | input | 1 | Bus select |
| enIn | input | 1 | Bus enable (access phase marker) |
| wrIn | input | 1 | Direction, 1 = write |
| addrIn | input | ADDR_W | Bus address |
| wdataIn | input | DATA_W | Write data |
| rdataIn | input | DATA_W | Read data |
| recValid | output | 1 | One-cycle record strobe |
| recWrite | output | 1 | Record direction, 1 = write |
| recAddr | output | ADDR_W | Record address |
| recData | output | DATA_W | Record data |
| errFlag | output | 1 | Sticky protocol fault flag |
| errCode | output | 2 | First fault kind: 0 none, 1 stray enable, 2 missing access, 3 unstable setup/access |

## Verification
Single write and single read transfers are run with read data that differs between setup and access. This separates sampling in the access cycle from sampling in the setup cycle. Back-to-back transfers and idle cycles with changing address lines check that legal traffic raises no fault. Each fault kind is caused on its own after a reset: stray enable, setup abandoned for idle, setup followed by a second setup, and address, direction or write-data changes. The last group tells the three codes apart and shows that a restarted setup still records. A later fault after the first, plus a later legal transfer, show that the code is sticky and that recognition goes on.

// File: rtl/apbMonPkg.sv
package apbMonPkg;

  typedef enum logic [1:0] {
    FAULT_NONE     = 2'd0,
    FAULT_STRAY_EN = 2'd1,
    FAULT_NO_ACC   = 2'd2,
    FAULT_UNSTABLE = 2'd3
  } faultKind_t;

  typedef struct packed {
    logic       capture;
    logic       emit;
    logic       raise;
    faultKind_t kind;
  } monStrobe_t;

endpackage

// File: rtl/apbMonCtrl.sv
module apbMonCtrl
  import apbMonPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selIn,
  input  logic       enIn,
  input  logic       mismatch,
  output monStrobe_t strb
);

  typedef enum logic {PH_IDLE, PH_SETUP} phase_t;

  phase_t phase, phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (enIn) begin
          strb.raise = 1'b1;
          strb.kind  = FAULT_STRAY_EN;
        end else if (selIn) begin
          strb.capture = 1'b1;
          phaseNext    = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (selIn && enIn) begin
          if (mismatch) begin
            strb.raise = 1'b1;
            strb.kind  = FAULT_UNSTABLE;
          end else begin
            strb.emit = 1'b1;
          end
          phaseNext = PH_IDLE;
        end else begin
          strb.raise = 1'b1;
          strb.kind  = FAULT_NO_ACC;
          if (selIn && !enIn) begin
            strb.capture = 1'b1;
            phaseNext    = PH_SETUP;
          end else begin
            phaseNext = PH_IDLE;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // An emitted record must come from a setup seen on the previous edge
  assert_emit_after_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |-> $past(selIn && !enIn));

  // Enable while idle can never be accepted silently
  assert_idle_enable_flagged_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && !selIn) |-> (strb.raise && !strb.emit));

endmodule

// File: rtl/apbMonData.sv
module apbMonData
  import apbMonPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0] rdataIn,
  input  monStrobe_t        strb,
  output logic              mismatch,
  output logic              recValid,
  output logic              recWrite,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData,
  output logic              errFlag,
  output logic [1:0]        errCode
);

  logic              capWr;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capWd;

  always_comb begin
    mismatch = (addrIn != capAddr) || (wrIn != capWr) ||
               (capWr && (wdataIn != capWd));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWr   <= 1'b0;
      capAddr <= '0;
      capWd   <= '0;
    end else if (strb.capture) begin
      capWr   <= wrIn;
      capAddr <= addrIn;
      capWd   <= wdataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recValid <= 1'b0;
      recWrite <= 1'b0;
      recAddr  <= '0;
      recData  <= '0;
    end else begin
      recValid <= strb.emit;
      if (strb.emit) begin
        recWrite <= capWr;
        recAddr  <= capAddr;
        recData  <= capWr ? capWd : rdataIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errCode <= 2'd0;
    end else if (strb.raise && !errFlag) begin
      errFlag <= 1'b1;
      errCode <= strb.kind;
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);

  assert_sticky_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(errCode)));

  assert_code_named_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errCode != 2'd0));

endmodule

// File: rtl/apbXferMonitor.sv
module apbXferMonitor
  import apbMonPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enIn,
  input  logic              wrIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0] rdataIn,
  output logic              recValid,
  output logic              recWrite,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData,
  output logic              errFlag,
  output logic [1:0]        errCode
);

  monStrobe_t strb;
  logic       mismatch;

  apbMonCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    (selIn),
    .enIn     (enIn),
    .mismatch (mismatch),
    .strb     (strb)
  );

  apbMonData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .wrIn     (wrIn),
    .addrIn   (addrIn),
    .wdataIn  (wdataIn),
    .rdataIn  (rdataIn),
    .strb     (strb),
    .mismatch (mismatch),
    .recValid (recValid),
    .recWrite (recWrite),
    .recAddr  (recAddr),
    .recData  (recData),
    .errFlag  (errFlag),
    .errCode  (errCode)
  );

  assert_stray_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && !selIn) |=> errFlag);

  assert_record_after_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> $past(selIn && enIn));

  assert_write_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recWrite) |-> (recData == $past(wdataIn)));

  assert_read_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recWrite) |-> (recData == $past(rdataIn)));

endmodule

// File: tb/sim_apbXferMonitor.sv
`timescale 1ns/1ps
module sim_apbXferMonitor;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0, rd = '0;
  logic recValid, recWrite, errFlag;
  logic [AW-1:0] recAddr;
  logic [DW-1:0] recData;
  logic [1:0] errCode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit started = 0;
  string phaseReq = "R1";

  always #4 clk = ~clk;

  apbXferMonitor #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .selIn(sel), .enIn(en), .wrIn(wr),
    .addrIn(addr), .wdataIn(wd), .rdataIn(rd),
    .recValid(recValid), .recWrite(recWrite), .recAddr(recAddr),
    .recData(recData), .errFlag(errFlag), .errCode(errCode)
  );

  // Behavioural reference model
  bit mPend = 0, mWr = 0;
  int mAddr = 0;
  longint mWd = 0;
  bit eValid = 0, eWr = 0, eErr = 0;
  int eAddr = 0, eCode = 0;
  longint eData = 0;

  function automatic void fault(int k);
    if (!eErr) begin eErr = 1; eCode = k; end
  endfunction

  always @(posedge clk) begin
    eValid = 0;
    if (!rstN) begin
      mPend = 0; eErr = 0; eCode = 0;
    end else if (mPend) begin
      if (sel && en) begin
        if (int'(addr) == mAddr && wr == mWr && (!wr || longint'(wd) == mWd)) begin
          eValid = 1; eWr = wr; eAddr = int'(addr);
          eData = wr ? longint'(wd) : longint'(rd);
        end else fault(3);
        mPend = 0;
      end else begin
        fault(2);
        mPend = sel && !en;
        mWr = wr; mAddr = int'(addr); mWd = longint'(wd);
      end
    end else begin
      if (en) fault(1);
      else if (sel) begin
        mPend = 1; mWr = wr; mAddr = int'(addr); mWd = longint'(wd);
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (recValid !== eValid || errFlag !== eErr || int'(errCode) != eCode ||
          (eValid && (recWrite !== eWr || int'(recAddr) != eAddr ||
                      longint'(recData) != eData))) begin
        failures++;
        $display("FAIL %s model compare: valid=%0b wr=%0b addr=%h data=%h err=%0b code=%0d expected valid=%0b wr=%0b addr=%h data=%h err=%0b code=%0d",
                 phaseReq, recValid, recWrite, recAddr, recData, errFlag, errCode,
                 eValid, eWr, eAddr, eData, eErr, eCode);
      end
    end
  end

  task automatic drv(bit s, bit e, bit w, int a, longint d, longint r);
    @(negedge clk);
    #1;
    sel = s; en = e; wr = w; addr = AW'(a); wd = DW'(d); rd = DW'(r);
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 0; sel = 0; en = 0;
    @(negedge clk); #1;
    rstN = 1;
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    doReset();
    started = 1;
    drv(0,0,0,0,0,0);
    chk("R1", "recValid after reset", recValid, 0);
    chk("R1", "errFlag after reset", errFlag, 0);
    chk("R1", "errCode after reset", errCode, 0);

    phaseReq = "R10";
    for (int i = 0; i < 4; i++) drv(0,0,i%2,16'h1111*i,32'hA5A5_0000+i,i);
    drv(0,0,0,0,0,0);
    chk("R10", "idle no record", recValid, 0);
    chk("R10", "idle no fault", errFlag, 0);

    phaseReq = "R2";
    drv(1,0,1,16'h1234,32'hDEAD_BEEF,32'h1);
    drv(1,1,1,16'h1234,32'hDEAD_BEEF,32'h2);
    drv(0,0,0,0,0,0);
    chk("R2", "write recValid", recValid, 1);
    chk("R2", "write recWrite", recWrite, 1);
    chk("R2", "write recAddr", recAddr, 16'h1234);
    chk("R2", "write recData", recData, 32'hDEAD_BEEF);
    drv(0,0,0,0,0,0);
    chk("R4", "recValid one cycle", recValid, 0);

    phaseReq = "R3";
    drv(1,0,0,16'h0040,32'h0,32'h1111_1111);
    drv(1,1,0,16'h0040,32'h5,32'h2222_2222);
    drv(0,0,0,0,0,32'h3333_3333);
    chk("R3", "read recValid", recValid, 1);
    chk("R3", "read recWrite", recWrite, 0);
    chk("R3", "read data from access cycle", recData, 32'h2222_2222);

    phaseReq = "R9";
    drv(1,0,1,16'h0100,32'h0000_00AA,0);
    drv(1,1,1,16'h0100,32'h0000_00AA,0);
    drv(1,0,0,16'h0200,0,0);
    chk("R9", "first of pair recorded", recValid, 1);
    drv(1,1,0,16'h0200,0,32'h0000_BBBB);
    chk("R9", "gap after first record", recValid, 0);
    drv(0,0,0,0,0,0);
    chk("R9", "second of pair recorded", recData, 32'h0000_BBBB);
    chk("R9", "no fault on back-to-back", errFlag, 0);

    phaseReq = "R5";
    drv(0,1,0,0,0,0);
    drv(0,0,0,0,0,0);
    chk("R5", "enable without select code", errCode, 1);
    chk("R5", "enable without select flag", errFlag, 1);
    doReset();
    drv(1,1,0,16'h8,0,0);
    drv(0,0,0,0,0,0);
    chk("R5", "access without setup code", errCode, 1);
    chk("R5", "access without setup no record", recValid, 0);

    phaseReq = "R6";
    doReset();
    drv(1,0,1,16'h10,32'h7,0);
    drv(0,0,0,0,0,0);
    drv(0,0,0,0,0,0);
    chk("R6", "setup then idle code", errCode, 2);
    doReset();
    drv(1,0,1,16'h20,32'h9,0);
    drv(1,0,1,16'h24,32'hC,0);
    drv(1,1,1,16'h24,32'hC,0);
    drv(0,0,0,0,0,0);
    chk("R6", "double setup code", errCode, 2);
    chk("R6", "restarted setup recorded", recValid, 1);
    chk("R6", "restarted setup address", recAddr, 16'h24);

    phaseReq = "R7";
    doReset();
    drv(1,0,1,16'h30,32'h1,0);
    drv(1,1,1,16'h34,32'h1,0);
    drv(0,0,0,0,0,0);
    chk("R7", "address change code", errCode, 3);
    chk("R7", "address change no record", recValid, 0);
    doReset();
    drv(1,0,1,16'h30,32'h1,0);
    drv(1,1,0,16'h30,32'h1,0);
    drv(0,0,0,0,0,0);
    chk("R7", "direction change code", errCode, 3);
    doReset();
    drv(1,0,1,16'h30,32'h1,0);
    drv(1,1,1,16'h30,32'h2,0);
    drv(0,0,0,0,0,0);
    chk("R7", "write data change code", errCode, 3);
    chk("R7", "write data change no record", recValid, 0);

    phaseReq = "R8";
    drv(0,1,0,0,0,0);
    drv(0,0,0,0,0,0);
    chk("R8", "code keeps first fault", errCode, 3);
    chk("R8", "flag stays set", errFlag, 1);
    drv(1,0,0,16'h50,0,0);
    drv(1,1,0,16'h50,0,32'h4444);
    drv(0,0,0,0,0,0);
    chk("R8", "record after fault", recValid, 1);
    chk("R8", "record data after fault", recData, 32'h4444);

    phaseReq = "R1";
    doReset();
    drv(0,0,0,0,0,0);
    chk("R1", "reset clears flag", errFlag, 0);
    chk("R1", "reset clears code", errCode, 0);
    drv(0,0,0,0,0,0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule